// File: doc/BRIEF.md
# Serial Adapter Register Block

This block is the processor-facing side of an asynchronous serial adapter. It has four byte-wide registers on a 2-bit address: a data location, a status location, a command register and a control register. Writes to the data location load a transmit holding register, and reads from it return the last received byte. The block drives an active-high interrupt request. On the line side, a strobe with a byte delivers received characters. A valid/taken handshake passes transmit bytes to an external shift register. Bit-level shifting, baud timing and modem pins are outside this block.

A processor read with side effects uses `rd_en`. The read data is combinational on `rd_data`, and the side effects of the read take place at the clock edge that ends the read cycle. A separate debug port (`dbg_addr`/`dbg_data`) returns the same register view with no side effects. A write of any value to the status location is a software reset. It clears the overrun flag and the low command bits. It does not touch the parity bits, the control register, the full/empty flags or a pending interrupt.

Top module: `uart_reg_block`

## Requirements
- R1: After hardware reset, status reads 0x10, command reads 0x02, control reads 0x00, `irq` is low and `tx_valid` is low.
- R2: The address map is 0 = data, 1 = status (on reads), 2 = command and 3 = control. Status bit 7 is the interrupt flag, bit 4 is transmit-empty, bit 3 is receive-full and bit 2 is overrun. Bits 6, 5, 1 and 0 read 0.
- R3: A processor read (`rd_en`) of address 0 returns the held byte. It clears both receive-full and overrun at that edge.
- R4: When a byte arrives while receive-full is set and no data read occurs in that cycle, overrun sets and the held byte is kept. The new byte is discarded.
- R5: Debug reads of any address change no flag and no register.
- R6: With command bit 1 = 0, every received byte sets status bit 7 and raises `irq` one cycle after the strobe. With command bit 1 = 1, received bytes leave both unchanged.
- R7: A write to address 0 clears transmit-empty and presents the byte on `tx_byte` with `tx_valid` high. When `tx_taken` is high while `tx_valid` is high, transmit-empty sets at that edge.
- R8: The transmit interrupt fires only when the shifter takes a byte while command bits 3:2 equal 01. A write to address 0 never raises `irq`.
- R9: A write to address 1, with any value, clears status bit 2 only.
- R10: A write to address 1 keeps command bits 7:5 and sets bits 4:0 to 00010. The control register is unchanged.
- R11: A processor read of address 1 clears the interrupt flag and `irq` at that edge, unless a new interrupt event occurs in the same cycle. A debug read of status does not clear it.
- R12: A data read and an arriving byte in the same cycle return the old byte and store the new one. Receive-full stays set and overrun is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Processor register address |
| wr_en | input | 1 | Processor write strobe |
| wr_data | input | 8 | Processor write data |
| rd_en | input | 1 | Processor read strobe (side effects at edge) |
| rd_data | output | 8 | Register view at `addr` |
| dbg_addr | input | 2 | Debug read address |
| dbg_data | output | 8 | Side-effect-free register view at `dbg_addr` |
| rx_strobe | input | 1 | Received byte available this cycle |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte pending for the shifter |
| tx_byte | output | 8 | Pending transmit byte |
| tx_taken | input | 1 | Shifter accepts the pending byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
Several behaviours are checked by assertions on every cycle:
- the held byte survives an overrun;
- a data read clears the receive flags;
- a write and a handshake move transmit-empty;
- the software reset rewrites the command register and leaves control alone;
- a rising interrupt always follows an enabled receive or transmit event.

The bench scenarios cover what needs a sequence of register accesses. They sweep every command value through the software reset and every low command setting through both interrupt sources. They also rebuild the 0x8C-to-0x88 status case, show that debug reads have no side effects, and check a data read that meets an arriving byte in the same cycle.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_CTL  = 2'd3
  } reg_sel_e;

  localparam int unsigned ST_IRQ = 7;
  localparam int unsigned ST_TXE = 4;
  localparam int unsigned ST_RXF = 3;
  localparam int unsigned ST_OVR = 2;

  localparam int unsigned CMD_KEEP_LSB = 5;
  localparam logic [CMD_KEEP_LSB-1:0] CMD_LOW_DEFAULT = 5'b00010;
  localparam int unsigned CMD_RXOFF_BIT = 1;
  localparam logic [1:0] TXIRQ_CODE = 2'b01;
endpackage

// File: rtl/rx_hold.sv
module rx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arrive,
  input  logic [DW-1:0] arrive_data,
  input  logic          take,
  input  logic          prst,
  output logic [DW-1:0] data_q,
  output logic          full_q,
  output logic          ovr_q
);
  logic          full_d, ovr_d, load;

  always_comb begin
    full_d = full_q;
    ovr_d  = ovr_q;
    load   = 1'b0;
    if (take) begin
      full_d = 1'b0;
      ovr_d  = 1'b0;
    end
    if (prst) ovr_d = 1'b0;
    if (arrive) begin
      if (full_q && !take) begin
        ovr_d = 1'b1;
      end else begin
        full_d = 1'b1;
        load   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      ovr_q  <= ovr_d;
      if (load) data_q <= arrive_data;
    end
  end

  p_overrun_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive && full_q && !take) |=> (ovr_q && full_q && data_q == $past(data_q)));

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !arrive) |=> (!full_q && !ovr_q));

  p_read_meets_arrival_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (take && arrive) |=> (full_q && !ovr_q && data_q == $past(arrive_data)));
endmodule

// File: rtl/tx_hold.sv
module tx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wr_data,
  input  logic          taken,
  output logic          empty_q,
  output logic [DW-1:0] byte_q,
  output logic          done
);
  logic empty_d;

  assign done = taken && !empty_q;

  always_comb begin
    empty_d = empty_q;
    if (wr)        empty_d = 1'b0;
    else if (done) empty_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      byte_q  <= '0;
    end else begin
      empty_q <= empty_d;
      if (wr) byte_q <= wr_data;
    end
  end

  p_write_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (!empty_q && byte_q == $past(wr_data)));

  p_taken_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !empty_q && !wr) |=> empty_q);
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import uart_reg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic          ctl_we,
  input  logic          prst,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] ctl_q
);
  localparam logic [DW-1:0] CMD_RESET = {{(DW-CMD_KEEP_LSB){1'b0}}, CMD_LOW_DEFAULT};
  logic [DW-1:0] cmd_d;

  always_comb begin
    cmd_d = cmd_q;
    if (cmd_we)    cmd_d = wdata;
    else if (prst) cmd_d = {cmd_q[DW-1:CMD_KEEP_LSB], CMD_LOW_DEFAULT};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_RESET;
      ctl_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      if (ctl_we) ctl_q <= wdata;
    end
  end

  p_prst_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (prst && !cmd_we && !ctl_we) |=>
      (cmd_q[DW-1:CMD_KEEP_LSB] == $past(cmd_q[DW-1:CMD_KEEP_LSB]) &&
       cmd_q[CMD_KEEP_LSB-1:0] == CMD_LOW_DEFAULT && $stable(ctl_q)));
endmodule

// File: rtl/uart_reg_block.sv
module uart_reg_block
  import uart_reg_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic [1:0]    dbg_addr,
  output logic [DW-1:0] dbg_data,
  input  logic          rx_strobe,
  input  logic [DW-1:0] rx_byte,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte,
  input  logic          tx_taken,
  output logic          irq
);
  logic [DW-1:0] rx_q, cmd_q, ctl_q, status;
  logic          rx_full, rx_ovr, tx_empty, tx_done;
  logic          data_wr, data_rd, stat_wr, stat_rd, cmd_wr, ctl_wr;
  logic          rx_ev, tx_ev, irq_q, irq_d;

  assign data_wr = wr_en && (reg_sel_e'(addr) == SEL_DATA);
  assign stat_wr = wr_en && (reg_sel_e'(addr) == SEL_STAT);
  assign cmd_wr  = wr_en && (reg_sel_e'(addr) == SEL_CMD);
  assign ctl_wr  = wr_en && (reg_sel_e'(addr) == SEL_CTL);
  assign data_rd = rd_en && (reg_sel_e'(addr) == SEL_DATA);
  assign stat_rd = rd_en && (reg_sel_e'(addr) == SEL_STAT);

  rx_hold #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .arrive(rx_strobe), .arrive_data(rx_byte),
    .take(data_rd), .prst(stat_wr), .data_q(rx_q), .full_q(rx_full), .ovr_q(rx_ovr)
  );

  tx_hold #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .wr(data_wr), .wr_data(wr_data), .taken(tx_taken),
    .empty_q(tx_empty), .byte_q(tx_byte), .done(tx_done)
  );

  cfg_regs #(.DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_wr), .ctl_we(ctl_wr), .prst(stat_wr),
    .wdata(wr_data), .cmd_q(cmd_q), .ctl_q(ctl_q)
  );

  assign rx_ev = rx_strobe && !cmd_q[CMD_RXOFF_BIT];
  assign tx_ev = tx_done && (cmd_q[3:2] == TXIRQ_CODE);

  always_comb begin
    irq_d = irq_q;
    if (rx_ev || tx_ev) irq_d = 1'b1;
    else if (stat_rd)   irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_comb begin
    status         = '0;
    status[ST_IRQ] = irq_q;
    status[ST_TXE] = tx_empty;
    status[ST_RXF] = rx_full;
    status[ST_OVR] = rx_ovr;
  end

  function automatic logic [DW-1:0] view(input logic [1:0] a, input logic [DW-1:0] rx,
                                         input logic [DW-1:0] st, input logic [DW-1:0] cm,
                                         input logic [DW-1:0] ct);
    case (reg_sel_e'(a))
      SEL_DATA: view = rx;
      SEL_STAT: view = st;
      SEL_CMD:  view = cm;
      default:  view = ct;
    endcase
  endfunction

  assign rd_data  = view(addr, rx_q, status, cmd_q, ctl_q);
  assign dbg_data = view(dbg_addr, rx_q, status, cmd_q, ctl_q);
  assign tx_valid = !tx_empty;
  assign irq      = irq_q;

  p_irq_has_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((rx_strobe && !cmd_q[1]) ||
                         (tx_valid && tx_taken && cmd_q[3:2] == 2'b01)));

  p_status_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd1 && !rx_strobe && !(tx_valid && tx_taken)) |=> !irq);

  p_write_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && wr_en && addr == 2'd0 && !rx_strobe && !tx_taken) |=> !irq);
endmodule

// File: tb/sim_uart_reg_block.sv
`timescale 1ns/1ps
module sim_uart_reg_block;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0, dbg_addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, rx_strobe = 1'b0, tx_taken = 1'b0;
  logic [7:0] wr_data = '0, rx_byte = '0;
  logic [7:0] rd_data, dbg_data, tx_byte;
  logic       tx_valid, irq;
  logic [7:0] last_rd;
  int         n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  uart_reg_block u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
    .rx_strobe(rx_strobe), .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_taken(tx_taken), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] a, input logic w, input logic r, input logic [7:0] d,
                     input logic rs, input logic [7:0] rb, input logic tk);
    addr = a; wr_en = w; rd_en = r; wr_data = d;
    rx_strobe = rs; rx_byte = rb; tx_taken = tk;
    #0.5 last_rd = rd_data;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; rx_strobe = 1'b0; tx_taken = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    dbg_addr = a;
    #0.5 v = dbg_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d); cyc(a, 1, 0, d, 0, 0, 0); endtask
  task automatic rd(input logic [1:0] a); cyc(a, 0, 1, 0, 0, 0, 0); endtask
  task automatic rx(input logic [7:0] b); cyc(0, 0, 0, 0, 1, b, 0); endtask
  task automatic take(); cyc(0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got %h expected %h", 8'h1, 8'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(1, v); chk("R1 status", v, 8'h10);
    peek(2, v); chk("R1 command", v, 8'h02);
    peek(3, v); chk("R1 control", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);

    // R2 R6 receive with interrupt disabled by default command
    rx(8'h5A);
    peek(1, v); chk("R2 status after rx", v, 8'h18);
    chk("R6 irq off when disabled", {7'b0, irq}, 8'h00);
    // R4 overrun keeps first byte
    rx(8'hA5);
    peek(1, v); chk("R4 overrun status", v, 8'h1C);
    peek(0, v); chk("R4 held byte", v, 8'h5A);
    // R5 debug reads leave everything alone
    for (int i = 0; i < 4; i++) peek(2'(i), v);
    peek(1, v); chk("R5 status after debug reads", v, 8'h1C);
    peek(0, v); chk("R5 data after debug reads", v, 8'h5A);
    // R3 processor data read
    rd(0);
    chk("R3 read data", last_rd, 8'h5A);
    peek(1, v); chk("R3 flags cleared", v, 8'h10);

    // R6 R7 R8 R11 sweep low command bits
    for (int c = 0; c < 16; c++) begin
      logic [7:0] cmd = 8'(c);
      logic       rx_on = !cmd[1];
      logic       tx_on = (cmd[3:2] == 2'b01);
      wr(2, cmd);
      rd(1);
      rx(8'(8'h30 + c));
      chk("R6 irq after rx", {7'b0, irq}, {7'b0, rx_on});
      peek(1, v); chk("R6 status bit7", v, {rx_on, 3'b001, 1'b1, 3'b000});
      rd(0);
      chk("R3 sweep data", last_rd, 8'(8'h30 + c));
      rd(1);
      chk("R11 status read clears", {7'b0, irq}, 8'h00);
      wr(0, 8'(8'hC0 ^ c));
      chk("R8 write no irq", {7'b0, irq}, 8'h00);
      chk("R7 tx_valid", {7'b0, tx_valid}, 8'h01);
      chk("R7 tx_byte", tx_byte, 8'(8'hC0 ^ c));
      peek(1, v); chk("R7 txe cleared", v, 8'h00);
      take();
      chk("R8 irq after take", {7'b0, irq}, {7'b0, tx_on});
      chk("R7 tx_valid drop", {7'b0, tx_valid}, 8'h00);
      peek(1, v); chk("R7 txe set", v, {tx_on, 7'h10});
      if (tx_on) begin
        peek(1, v); chk("R11 debug read keeps irq", {7'b0, irq}, 8'h01);
      end
      rd(1);
      chk("R11 cleared after sweep", {7'b0, irq}, 8'h00);
    end

    // R9 software reset clears only overrun
    wr(2, 8'h00);
    rx(8'h61); rx(8'h62); wr(0, 8'h63);
    peek(1, v); chk("R9 before", v, 8'h8C);
    wr(1, 8'hFF);
    peek(1, v); chk("R9 after", v, 8'h88);
    chk("R9 irq held", {7'b0, irq}, 8'h01);
    take(); rd(0); rd(1);

    // R10 software reset on every command value and control value
    for (int c = 0; c < 256; c++) begin
      wr(2, 8'(c));
      wr(3, 8'(255 - c));
      wr(1, 8'(c * 7));
      peek(2, v); chk("R10 command", v, {8'(c) & 8'hE0} | 8'h02);
      peek(3, v); chk("R10 control", v, 8'(255 - c));
    end

    // R12 data read meeting an arriving byte
    wr(2, 8'h02);
    rx(8'h11);
    cyc(0, 0, 1, 0, 1, 8'h22, 0);
    chk("R12 old byte returned", last_rd, 8'h11);
    peek(1, v); chk("R12 status", v, 8'h18);
    peek(0, v); chk("R12 new byte held", v, 8'h22);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule